// File: doc/BRIEF.md
# USB Host Port Resume and Fault Status Register

This block is the status and control register for one root hub port of a USB 2.0 host. Software reaches it through a single-cycle register interface. The port's link logic feeds it four kinds of event: a J-to-K wake detected on the line, the port settling into high-speed idle, the over-current sense, and a port error found at the end-of-frame check.

The block keeps a force-resume bit, which can be set by software or by a wake event. While that bit reads one, the block drives resume signalling. When software writes the bit to zero, the bit is not cleared at once. It stays at one, and resume is still driven, until the port reports high-speed idle. A cycle counter raises a sticky timeout flag if idle does not arrive within the allowed window.

The block also mirrors the over-current condition, forces the port off while that condition lasts, and latches sticky change flags. Software clears each change flag by writing one to it. Only a wake event, and not a software write, produces the global port-change-detect pulse.

Top module: `usb_port_ctl`

## Requirements
- R1: When `jk_seen` is high while `port_susp` is high and the resume bit (bit 0) is zero, bit 0 reads one after that clock edge, and `pcd_pulse` is high for exactly that one following cycle.
- R2: A write with `wr_data[0]`=1 while bit 0 is zero sets bit 0 after that edge and never raises `pcd_pulse`.
- R3: `resume_drive` is high exactly while bit 0 reads one, except when the resume was started by the software write described in R11.
- R4: A write with `wr_data[0]`=0 while bit 0 is one starts an exit. Bit 0 keeps reading one until an edge at which `hs_idle` is high, and it reads zero after that edge.
- R5: If `hs_idle` has not arrived `EXIT_LIMIT` clock edges after the edge of the exit write, the resume-timeout flag (bit 4) reads one. Writing one to bit 4 clears it.
- R6: The over-current-active bit (bit 1) equals `oc_in` as sampled at the previous edge. Writes have no effect on bit 1.
- R7: `disable_req` is high while bit 1 is one. It is also high for the one cycle after an edge at which both `eof_err` and `port_en` are high.
- R8: The over-current-change flag (bit 2) sets whenever bit 1 is about to change value. Writing one to bit 2 clears it.
- R9: The enable-change flag (bit 3) sets only after an edge at which both `eof_err` and `port_en` are high. Enabling the port does not set it, and neither does an error while the port is disabled. Writing one to bit 3 clears it.
- R10: When a set condition for a flag and a write of one to that flag's bit fall on the same edge, the flag reads one afterwards.
- R11: A software write that sets bit 0 while `port_en` is high and `port_susp` is low sets the undefined-use flag (bit 5). In that case bit 0 still reads one, but `resume_drive` stays low. Writing one to bit 5 clears the flag.
- R12: After reset, every register bit and every output is zero. Bits above bit 5 always read zero.
- R13: `jk_seen` while `port_susp` is low changes neither bit 0 nor `pcd_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | REG_W | Write data: bit 0 resume, bits 2..5 write-one-to-clear |
| rdata | output | REG_W | Register read value |
| jk_seen | input | 1 | J-to-K wake transition detected |
| hs_idle | input | 1 | Port has reached high-speed idle |
| oc_in | input | 1 | Over-current sense |
| eof_err | input | 1 | Port error detected at the end-of-frame check |
| port_en | input | 1 | Port is currently enabled |
| port_susp | input | 1 | Port is currently suspended |
| resume_drive | output | 1 | Drive resume K signalling |
| disable_req | output | 1 | Request that the port be disabled |
| pcd_pulse | output | 1 | One-cycle global port-change-detect pulse |

## Verification
Every register field and `pcd_pulse` updates on the clock edge that samples its stimulus. Each check therefore sits at the falling edge that comes right after that rising edge. The one exception is the resume timeout, which is due exactly `EXIT_LIMIT` edges after the exit write. The bench checks it one cycle before and at that edge. Inputs change only at falling edges, so the due cycle of each result is fixed by counting rising edges from the stimulus.

// File: rtl/usb_port_ctl.sv
module usb_port_ctl #(
  parameter int EXIT_LIMIT = 120000,
  parameter int REG_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rdata,
  input  logic             jk_seen,
  input  logic             hs_idle,
  input  logic             oc_in,
  input  logic             eof_err,
  input  logic             port_en,
  input  logic             port_susp,
  output logic             resume_drive,
  output logic             disable_req,
  output logic             pcd_pulse
);
  localparam int CW = $clog2(EXIT_LIMIT + 1);
  localparam logic [CW-1:0] CNT_MAX  = CW'(EXIT_LIMIT);
  localparam logic [CW-1:0] CNT_TRIP = CW'(EXIT_LIMIT - 1);

  logic rsm, exiting, nodrv;
  logic oca, occ, pec, rto, ufl;
  logic pcd_q, err_q;
  logic [CW-1:0] cnt;

  wire hw_set   = jk_seen & port_susp;
  wire sw_set   = wr_en & wr_data[0];
  wire misuse   = port_en & ~port_susp;
  wire err_dis  = eof_err & port_en;
  wire oc_edge  = oc_in ^ oca;
  wire time_up  = exiting & ~hs_idle & (cnt == CNT_TRIP);

  assign rdata        = REG_W'({ufl, rto, pec, occ, oca, rsm});
  assign resume_drive = rsm & ~nodrv;
  assign disable_req  = oca | err_q;
  assign pcd_pulse    = pcd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsm <= 1'b0; exiting <= 1'b0; nodrv <= 1'b0; cnt <= '0;
      oca <= 1'b0; occ <= 1'b0; pec <= 1'b0; rto <= 1'b0; ufl <= 1'b0;
      pcd_q <= 1'b0; err_q <= 1'b0;
    end else begin
      pcd_q <= hw_set & ~rsm;
      err_q <= err_dis;
      oca   <= oc_in;

      if (oc_edge)                     occ <= 1'b1;
      else if (wr_en && wr_data[2])    occ <= 1'b0;

      if (err_dis)                     pec <= 1'b1;
      else if (wr_en && wr_data[3])    pec <= 1'b0;

      if (time_up)                     rto <= 1'b1;
      else if (wr_en && wr_data[4])    rto <= 1'b0;

      if (!rsm && !hw_set && sw_set && misuse) ufl <= 1'b1;
      else if (wr_en && wr_data[5])            ufl <= 1'b0;

      if (!rsm) begin
        if (hw_set) begin
          rsm   <= 1'b1;
          nodrv <= 1'b0;
        end else if (sw_set) begin
          rsm   <= 1'b1;
          nodrv <= misuse;
        end
      end else if (!exiting) begin
        if (wr_en && !wr_data[0]) begin
          exiting <= 1'b1;
          cnt     <= '0;
        end
      end else if (hs_idle) begin
        rsm     <= 1'b0;
        exiting <= 1'b0;
        nodrv   <= 1'b0;
      end else if (cnt != CNT_MAX) begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/usb_port_ctl_chk.sv
module usb_port_ctl_chk #(
  parameter int REG_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [REG_W-1:0] rdata,
  input logic             hs_idle,
  input logic             oc_in,
  input logic             eof_err,
  input logic             port_en,
  input logic             resume_drive,
  input logic             pcd_pulse
);
  // R1
  pcd_after_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pcd_pulse |-> $rose(rdata[0]));
  // R3
  drive_needs_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resume_drive |-> rdata[0]);
  // R4
  exit_on_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdata[0]) |-> $past(hs_idle));
  // R6
  oc_high_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oc_in |=> rdata[1]);
  // R6
  oc_low_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oc_in |=> !rdata[1]);
  // R9
  pec_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdata[3]) |-> $past(eof_err && port_en));
  // R12
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[REG_W-1:6] == '0);
endmodule

bind usb_port_ctl usb_port_ctl_chk #(.REG_W(REG_W)) i_usb_port_ctl_chk (
  .clk(clk), .rst_n(rst_n), .rdata(rdata), .hs_idle(hs_idle), .oc_in(oc_in),
  .eof_err(eof_err), .port_en(port_en), .resume_drive(resume_drive),
  .pcd_pulse(pcd_pulse)
);

// File: tb/test_usb_port_ctl.sv
module test_usb_port_ctl;
  localparam int LIM = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rdata;
  logic jk_seen = 0, hs_idle = 0, oc_in = 0, eof_err = 0, port_en = 0, port_susp = 0;
  logic resume_drive, disable_req, pcd_pulse;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  usb_port_ctl #(.EXIT_LIMIT(LIM), .REG_W(8)) i_usb_port_ctl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rdata(rdata),
    .jk_seen(jk_seen), .hs_idle(hs_idle), .oc_in(oc_in), .eof_err(eof_err),
    .port_en(port_en), .port_susp(port_susp), .resume_drive(resume_drive),
    .disable_req(disable_req), .pcd_pulse(pcd_pulse));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    tick();
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(5ns * 100000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic e_oca, e_occ, e_pec, b, w, d;
    tick(); tick();
    rst_n = 1'b1;
    tick();
    // R12 reset state
    chk("R12 reg", rdata, 0);
    chk("R12 outs", {resume_drive, disable_req, pcd_pulse}, 0);

    // R6 R7 R8 R10 over-current sweep with concurrent clears
    e_oca = 0; e_occ = 0;
    for (int p = 0; p < 64; p++) begin
      b = ((p * 37 + p / 3) >> 2) & 1;
      w = (p % 5 == 0);
      oc_in = b;
      if (w) begin wr_en = 1; wr_data = 8'h06; end
      tick();
      wr_en = 0; wr_data = '0;
      if (b != e_oca) e_occ = 1; else if (w) e_occ = 0;
      e_oca = b;
      chk("R6 oca", rdata[1], e_oca);
      chk("R8 R10 occ", rdata[2], e_occ);
      chk("R7 disable", disable_req, e_oca);
    end
    oc_in = 0; tick(); wr(8'h04);
    chk("R8 clear", rdata[2:1], 0);

    // R9 R10 R7 enable-change sweep
    e_pec = 0;
    for (int e = 0; e < 2; e++)
      for (int en = 0; en < 2; en++)
        for (int c = 0; c < 2; c++) begin
          eof_err = e[0]; port_en = en[0];
          if (c != 0) begin wr_en = 1; wr_data = 8'h08; end
          tick();
          wr_en = 0; wr_data = '0;
          d = e[0] & en[0];
          if (d) e_pec = 1; else if (c != 0) e_pec = 0;
          chk("R9 R10 pec", rdata[3], e_pec);
          chk("R7 err pulse", disable_req, d);
          eof_err = 0;
          tick();
          chk("R7 pulse end", disable_req, 0);
        end
    wr(8'h08);
    port_en = 0; tick(); port_en = 1; tick();
    chk("R9 enable no set", rdata[3], 0);

    // R13 wake ignored when not suspended
    port_susp = 0; jk_seen = 1; tick(); jk_seen = 0;
    chk("R13 bit", rdata[0], 0);
    chk("R13 pcd", pcd_pulse, 0);

    // R1 hardware wake
    port_susp = 1; jk_seen = 1; tick(); jk_seen = 0;
    chk("R1 bit", rdata[0], 1);
    chk("R1 pcd", pcd_pulse, 1);
    chk("R3 drive", resume_drive, 1);
    tick();
    chk("R1 pcd one cycle", pcd_pulse, 0);

    // R4 exit waits for idle
    wr(8'h00);
    for (int i = 0; i < 3; i++) tick();
    chk("R4 held", rdata[0], 1);
    chk("R3 still drive", resume_drive, 1);
    hs_idle = 1; tick(); hs_idle = 0;
    chk("R4 cleared", rdata[0], 0);
    chk("R3 drive off", resume_drive, 0);
    chk("R5 no timeout", rdata[4], 0);

    // R2 software resume, then R5 timeout
    wr(8'h01);
    chk("R2 bit", rdata[0], 1);
    chk("R2 no pcd", pcd_pulse, 0);
    chk("R3 sw drive", resume_drive, 1);
    wr(8'h00);
    for (int i = 1; i <= LIM; i++) begin
      tick();
      chk("R5 timeout", rdata[4], (i >= LIM) ? 1 : 0);
    end
    chk("R4 still held", rdata[0], 1);
    hs_idle = 1; tick(); hs_idle = 0;
    chk("R4 late idle", rdata[0], 0);
    wr(8'h10);
    chk("R5 clear", rdata[4], 0);

    // R11 undefined use
    port_susp = 0; port_en = 1;
    wr(8'h01);
    chk("R11 bit", rdata[0], 1);
    chk("R11 flag", rdata[5], 1);
    chk("R11 no drive", resume_drive, 0);
    wr(8'h20);
    hs_idle = 1; tick(); hs_idle = 0;
    chk("R11 exit", rdata, 0);

    // R6 RO write ignored
    wr(8'hFF & ~8'h01);
    chk("R6 R12 ro", rdata, 0);

    finish_run();
  end
endmodule